// File: doc/BRIEF.md
# Decode-Stage Stall Detector for Load-Use and Store-Data Hazards

This block sits in the decode stage of a five-stage in-order pipeline. It decides whether the instruction now in decode must wait one cycle. It looks at the opcode, function code and the two source register numbers of the decoded instruction. It also looks at the write-enable, memory-read flag and destination register of the instruction one stage ahead (the decode/execute register), and at the write-enable and destination of the instruction two stages ahead (the execute/memory register).

The block decodes which registers the instruction really reads, and the role each one plays. A register can be an ALU operand, the data register of a store, or not read at all. From that it raises a stall in two cases. The first is a load directly ahead that produces an ALU operand. The second is a store whose data register is produced two instructions ahead, where no forwarding path reaches it. The stall request freezes fetch and keeps the same instruction in decode. A companion output forces every control bit written into the decode/execute register to zero for that cycle. The block is purely combinational and holds no state.

Top module: `hz_stall_detect`

## Requirements
- R1: When the decode/execute stage holds a load (memory-read = 1, write-enable = 1) whose destination equals a register that the decoded instruction reads as an ALU operand, stall_req is 1. A non-load writer directly ahead does not stall.
- R2: Source use is decoded exactly. Register-format instructions (opcode 0x00 with funct 0x20 to 0x27 or 0x2A) read rs and rt. Shift-left (funct 0x00) reads only rt. Opcodes 0x08, 0x09, 0x0A, 0x0C, 0x0D and load 0x23 read only rs. Load-upper 0x0F, jump 0x02 and branches 0x04 and 0x05 read nothing for this detector. A match on a register that is not read never stalls.
- R3: For a store (opcode 0x2B), rs is an ALU operand and rt is the store data. A writer directly ahead that matches only rt causes no stall, even when it is a load.
- R4: A store whose data register rt matches the destination of a write-enabled instruction in the execute/memory stage stalls.
- R5: A write-enabled instruction in the execute/memory stage never stalls an instruction that is not a store, and never stalls on a store's rs.
- R6: A hazard counts only when the earlier stage has write-enable = 1 and a destination that is not register 0.
- R7: An unrecognised opcode, or opcode 0x00 with an unrecognised funct, never requests a stall.
- R8: idex_ctrl_zero equals stall_req in every cycle, so a stalled cycle writes all-zero control bits into decode/execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_opcode | input | 6 | Opcode of the instruction in decode |
| id_funct | input | 6 | Function code of the instruction in decode |
| id_rs | input | 5 | First source register number |
| id_rt | input | 5 | Second source register number |
| ex_reg_write | input | 1 | Decode/execute entry will write a register |
| ex_mem_read | input | 1 | Decode/execute entry is a load |
| ex_dst | input | 5 | Destination register of the decode/execute entry |
| mem_reg_write | input | 1 | Execute/memory entry will write a register |
| mem_dst | input | 5 | Destination register of the execute/memory entry |
| stall_req | output | 1 | Hold decode and freeze fetch this cycle |
| idex_ctrl_zero | output | 1 | Force all control bits written into decode/execute to zero |

## Verification
Assertions check on every evaluation that an unrecognised instruction never stalls and that immediate-format instructions never report rt as read. They also check that every comparator hit comes from a write-enabled stage with a non-zero destination, that a store-data hit always stalls, and that the clear signal tracks the stall. Only the bench's scenarios can show the right answer for particular encodings. These include a load ahead matching only an addi's rt, a load-upper, or a store's data register, and a store-data writer sitting in the execute/memory stage rather than directly ahead. Those cases depend on the meaning of the encodings, which the assertions cannot know.

// File: rtl/hz_pkg.sv
package hz_pkg;

  localparam int OP_W = 6;
  localparam int FN_W = 6;

  localparam logic [OP_W-1:0] OP_REG   = 6'h00;
  localparam logic [OP_W-1:0] OP_JMP   = 6'h02;
  localparam logic [OP_W-1:0] OP_BREQ  = 6'h04;
  localparam logic [OP_W-1:0] OP_BRNE  = 6'h05;
  localparam logic [OP_W-1:0] OP_ADDI  = 6'h08;
  localparam logic [OP_W-1:0] OP_ADDIU = 6'h09;
  localparam logic [OP_W-1:0] OP_SLTI  = 6'h0A;
  localparam logic [OP_W-1:0] OP_ANDI  = 6'h0C;
  localparam logic [OP_W-1:0] OP_ORI   = 6'h0D;
  localparam logic [OP_W-1:0] OP_LUI   = 6'h0F;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'h23;
  localparam logic [OP_W-1:0] OP_STORE = 6'h2B;

  localparam logic [FN_W-1:0] FN_SHL   = 6'h00;
  localparam logic [FN_W-1:0] FN_ALU_LO = 6'h20;
  localparam logic [FN_W-1:0] FN_ALU_HI = 6'h27;
  localparam logic [FN_W-1:0] FN_SLT   = 6'h2A;

  // How the decoded instruction uses its source register fields.
  typedef struct packed {
    logic known;       // opcode/funct recognised
    logic rs_alu;      // rs feeds the ALU
    logic rt_alu;      // rt feeds the ALU
    logic rt_store;    // rt is store data
  } src_use_t;

  function automatic src_use_t classify(input logic [OP_W-1:0] op,
                                        input logic [FN_W-1:0] fn);
    src_use_t u;
    u = '0;
    unique case (op)
      OP_REG: begin
        if (fn == FN_SHL) begin
          u.known  = 1'b1;
          u.rt_alu = 1'b1;
        end else if ((fn >= FN_ALU_LO && fn <= FN_ALU_HI) || fn == FN_SLT) begin
          u.known  = 1'b1;
          u.rs_alu = 1'b1;
          u.rt_alu = 1'b1;
        end
      end
      OP_ADDI, OP_ADDIU, OP_SLTI, OP_ANDI, OP_ORI, OP_LOAD: begin
        u.known  = 1'b1;
        u.rs_alu = 1'b1;
      end
      OP_STORE: begin
        u.known    = 1'b1;
        u.rs_alu   = 1'b1;
        u.rt_store = 1'b1;
      end
      OP_LUI, OP_JMP, OP_BREQ, OP_BRNE: begin
        u.known = 1'b1;
      end
      default: u = '0;
    endcase
    return u;
  endfunction

endpackage

// File: rtl/hz_src_decode.sv
module hz_src_decode
  import hz_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  input  logic [FN_W-1:0] funct,
  output src_use_t        use_o
);

  assign use_o = classify(opcode, funct);

  // Immediate-format opcodes must never claim rt as a read operand.
  always_comb begin
    a_r2_imm_no_rt: assert (!((opcode == OP_ADDI || opcode == OP_ADDIU ||
                               opcode == OP_SLTI || opcode == OP_ANDI  ||
                               opcode == OP_ORI  || opcode == OP_LUI   ||
                               opcode == OP_LOAD) &&
                              (use_o.rt_alu || use_o.rt_store)))
      else $error("R2: immediate opcode reports rt as read");
  end

endmodule

// File: rtl/hz_dst_match.sv
module hz_dst_match #(
  parameter int REG_AW = 5
) (
  input  logic              wr_en,
  input  logic [REG_AW-1:0] dst,
  input  logic [REG_AW-1:0] src,
  input  logic              src_used,
  output logic              hit
);

  logic dst_live;
  assign dst_live = wr_en && (dst != '0);
  assign hit      = dst_live && src_used && (dst == src);

  always_comb begin
    a_r6_hit_needs_live: assert (!hit || (wr_en && (src != '0) && src_used))
      else $error("R6: hit without a live writer");
  end

endmodule

// File: rtl/hz_stall_detect.sv
module hz_stall_detect #(
  parameter int REG_AW = 5
) (
  input  logic [5:0]        id_opcode,
  input  logic [5:0]        id_funct,
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic              ex_reg_write,
  input  logic              ex_mem_read,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              mem_reg_write,
  input  logic [REG_AW-1:0] mem_dst,
  output logic              stall_req,
  output logic              idex_ctrl_zero
);
  import hz_pkg::*;

  localparam int N_ALU_SRC = 2;

  src_use_t           src_use;
  logic [REG_AW-1:0]  alu_src  [N_ALU_SRC];
  logic [N_ALU_SRC-1:0] alu_used;
  logic [N_ALU_SRC-1:0] load_hit;
  logic               ex_is_load;
  logic               load_use_evt;
  logic               store_data_evt;

  hz_src_decode u_dec (
    .opcode (id_opcode),
    .funct  (id_funct),
    .use_o  (src_use)
  );

  assign alu_src[0]  = id_rs;
  assign alu_src[1]  = id_rt;
  assign alu_used[0] = src_use.rs_alu;
  assign alu_used[1] = src_use.rt_alu;
  assign ex_is_load  = ex_reg_write && ex_mem_read;

  // One comparator per ALU operand against a load directly ahead.
  for (genvar k = 0; k < N_ALU_SRC; k++) begin : g_ld
    hz_dst_match #(.REG_AW(REG_AW)) u_ld (
      .wr_en    (ex_is_load),
      .dst      (ex_dst),
      .src      (alu_src[k]),
      .src_used (alu_used[k]),
      .hit      (load_hit[k])
    );
  end

  // Store data against a writer two ahead; one ahead is forwarded.
  hz_dst_match #(.REG_AW(REG_AW)) u_st (
    .wr_en    (mem_reg_write),
    .dst      (mem_dst),
    .src      (id_rt),
    .src_used (src_use.rt_store),
    .hit      (store_data_evt)
  );

  assign load_use_evt   = |load_hit;
  assign stall_req      = load_use_evt || store_data_evt;
  assign idex_ctrl_zero = load_use_evt || store_data_evt;

  always_comb begin
    a_r7_unknown_no_stall: assert (src_use.known || !stall_req)
      else $error("R7: stall on unrecognised instruction");
    a_r4_store_hit_stalls: assert (!store_data_evt || stall_req)
      else $error("R4: store-data hit without stall");
    a_r8_clear_tracks: assert (idex_ctrl_zero == stall_req)
      else $error("R8: control clear differs from stall");
    a_r1_load_needs_memread: assert (!load_use_evt || ex_mem_read)
      else $error("R1: load-use event without a load ahead");
  end

endmodule

// File: tb/hz_stall_detect_tb_top.sv
module hz_stall_detect_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [5:0] op, fn;
  logic [4:0] rs, rt, exd, memd;
  logic       exw, exr, memw;
  logic       stall, czero;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  hz_stall_detect dut_i (
    .id_opcode(op), .id_funct(fn), .id_rs(rs), .id_rt(rt),
    .ex_reg_write(exw), .ex_mem_read(exr), .ex_dst(exd),
    .mem_reg_write(memw), .mem_dst(memd),
    .stall_req(stall), .idex_ctrl_zero(czero)
  );

  // {req[39:36], op, fn, rs, rt, exw, exr, exd, memw, memd, expect}
  localparam int NV = 20;
  localparam logic [39:0] VEC [NV] = '{
    {4'd1, 6'h00, 6'h20, 5'd1,  5'd2,  1'b1, 1'b1, 5'd1,  1'b0, 5'd0,  1'b1}, // R1 add rs
    {4'd1, 6'h00, 6'h20, 5'd1,  5'd2,  1'b1, 1'b1, 5'd2,  1'b0, 5'd0,  1'b1}, // R1 add rt
    {4'd1, 6'h00, 6'h20, 5'd1,  5'd2,  1'b1, 1'b0, 5'd1,  1'b0, 5'd0,  1'b0}, // R1 non-load
    {4'd2, 6'h08, 6'h00, 5'd3,  5'd4,  1'b1, 1'b1, 5'd4,  1'b0, 5'd0,  1'b0}, // R2 addi rt only
    {4'd2, 6'h08, 6'h00, 5'd3,  5'd4,  1'b1, 1'b1, 5'd3,  1'b0, 5'd0,  1'b1}, // R2 addi rs
    {4'd2, 6'h0F, 6'h00, 5'd5,  5'd6,  1'b1, 1'b1, 5'd5,  1'b0, 5'd0,  1'b0}, // R2 lui
    {4'd2, 6'h00, 6'h00, 5'd0,  5'd7,  1'b1, 1'b1, 5'd7,  1'b0, 5'd0,  1'b1}, // R2 shift rt
    {4'd2, 6'h23, 6'h00, 5'd8,  5'd9,  1'b1, 1'b1, 5'd9,  1'b0, 5'd0,  1'b0}, // R2 load rt
    {4'd2, 6'h23, 6'h00, 5'd8,  5'd9,  1'b1, 1'b1, 5'd8,  1'b0, 5'd0,  1'b1}, // R2 load rs
    {4'd2, 6'h04, 6'h00, 5'd1,  5'd2,  1'b1, 1'b1, 5'd1,  1'b0, 5'd0,  1'b0}, // R2 branch
    {4'd3, 6'h2B, 6'h00, 5'd10, 5'd11, 1'b1, 1'b1, 5'd11, 1'b0, 5'd0,  1'b0}, // R3 data fwd
    {4'd3, 6'h2B, 6'h00, 5'd10, 5'd11, 1'b1, 1'b1, 5'd10, 1'b0, 5'd0,  1'b1}, // R3 base
    {4'd4, 6'h2B, 6'h00, 5'd10, 5'd11, 1'b0, 1'b0, 5'd0,  1'b1, 5'd11, 1'b1}, // R4 two ahead
    {4'd5, 6'h2B, 6'h00, 5'd10, 5'd11, 1'b0, 1'b0, 5'd0,  1'b1, 5'd10, 1'b0}, // R5 store rs
    {4'd5, 6'h00, 6'h20, 5'd12, 5'd13, 1'b0, 1'b0, 5'd0,  1'b1, 5'd12, 1'b0}, // R5 add
    {4'd6, 6'h00, 6'h20, 5'd0,  5'd0,  1'b1, 1'b1, 5'd0,  1'b0, 5'd0,  1'b0}, // R6 reg zero
    {4'd6, 6'h00, 6'h20, 5'd1,  5'd2,  1'b0, 1'b1, 5'd1,  1'b0, 5'd0,  1'b0}, // R6 no write
    {4'd6, 6'h2B, 6'h00, 5'd10, 5'd11, 1'b0, 1'b0, 5'd0,  1'b0, 5'd11, 1'b0}, // R6 mem off
    {4'd7, 6'h00, 6'h3F, 5'd1,  5'd2,  1'b1, 1'b1, 5'd1,  1'b1, 5'd2,  1'b0}, // R7 funct
    {4'd7, 6'h3E, 6'h00, 5'd1,  5'd2,  1'b1, 1'b1, 5'd1,  1'b1, 5'd2,  1'b0}  // R7 opcode
  };

  task automatic check(input int req, input logic exp);
    @(negedge clk);
    n_run++;
    if (stall !== exp) begin
      n_fail++;
      $display("FAIL R%0d stall actual=%b expected=%b (op=%h fn=%h)", req, stall, exp, op, fn);
    end
    n_run++;
    if (czero !== exp) begin // R8
      n_fail++;
      $display("FAIL R8 ctrl_zero actual=%b expected=%b", czero, exp);
    end
  endtask

  task automatic apply(input logic [39:0] v);
    @(posedge clk);
    {op, fn, rs, rt, exw, exr, exd, memw, memd} = v[35:1];
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    {op, fn, rs, rt, exw, exr, exd, memw, memd} = '0;
    // Reset state: a nop with idle stages ahead does not stall (R6, R8).
    check(6, 1'b0);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      check(int'(VEC[i][39:36]), VEC[i][0]);
    end

    // R2 corner: each immediate opcode ignores an rt-only load match.
    for (int k = 0; k < 5; k++) begin
      @(posedge clk);
      op = (k == 0) ? 6'h09 : (k == 1) ? 6'h0A : (k == 2) ? 6'h0C : (k == 3) ? 6'h0D : 6'h08;
      fn = 6'h00; rs = 5'd20; rt = 5'd21;
      exw = 1'b1; exr = 1'b1; exd = 5'd21; memw = 1'b0; memd = 5'd0;
      check(2, 1'b0);
    end

    // R1 corner: every non-zero destination against register-format rs.
    for (int d = 1; d < 32; d++) begin
      @(posedge clk);
      op = 6'h00; fn = 6'h2A; rs = 5'(d); rt = 5'(32 - d);
      exw = 1'b1; exr = 1'b1; exd = 5'(d); memw = 1'b0; memd = 5'd0;
      check(1, 1'b1);
    end

    // R4 and R3 together: load one ahead on data, writer two ahead on data.
    @(posedge clk);
    op = 6'h2B; fn = 6'h00; rs = 5'd3; rt = 5'd17;
    exw = 1'b1; exr = 1'b1; exd = 5'd17; memw = 1'b1; memd = 5'd17;
    check(4, 1'b1);

    // R5: writer two ahead on an addi source does not stall.
    @(posedge clk);
    op = 6'h08; rs = 5'd9; rt = 5'd1;
    exw = 1'b0; exr = 1'b0; exd = 5'd0; memw = 1'b1; memd = 5'd9;
    check(5, 1'b0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule